// File: doc/BRIEF.md
# Smart-Card Character Link with Retry

This block moves single characters across the one open-drain data line of a smart card, using the character-level error handling of the T=0 protocol. The line is half duplex, so the engine either sends or receives, never both at once. Each character on the line has a low start bit, eight data bits and an even parity bit, followed by a two-ETU guard period in which nothing is driven. An ETU is one bit time and lasts `ETU_CLKS` clock cycles. The engine does not generate the card clock, parse the answer-to-reset or run the T=1 block protocol.

When it sends, the engine releases the line after the parity bit and samples it one ETU into the guard period. A low level there is the receiver's error signal. The engine then sends the same character again, until a programmable repetition limit is used up. At that point it gives up, raises a sticky error flag, and leaves the repetition count readable. When it receives, the engine samples every bit at mid-ETU and checks parity. On a parity failure it pulls the line low during the guard period to ask for a repeat, until a programmable iteration limit is reached. After that it accepts the character and flags it. A configuration input selects the inverse data convention. In that convention data levels are complemented and bits travel most-significant first, in both directions.

The line is modelled as an input `line_in`, which is the wired level already synchronised to `clk`, and an output `line_drive_low`, which is the pull-down enable.

Top module: `sc_char_link`

## Requirements
- R1: While `rst_n` is low and after it, the line is not driven, `busy`, all event pulses, `err_count`, `err_sticky` and `rx_data` are zero.
- R2: `tx_start` seen while idle sends a character from the next cycle: start bit low, data LSB first, then the parity bit, which is 1 when `tx_data` has an odd number of ones. Each bit lasts `ETU_CLKS` cycles, and 2 ETUs of released line follow. With no error signal, `tx_done` pulses 12 ETUs after the start bit began and `busy` drops at the same time.
- R3: With `cfg_inverse` = 1, line bit n+1 (n = 0..7) carries the complement of data bit 7-n, and the parity line level is the complement of the direct-convention parity. Reception decodes with the same mapping.
- R4: A low line sampled at cycle `ETU_CLKS`-1 of the transmit guard is an error signal. If `err_count` is below `cfg_max_rep`, `err_count` increments and the same character starts again right after the guard.
- R5: An error signal received while `err_count` equals `cfg_max_rep` ends the attempt: `tx_fail` pulses instead of `tx_done`, no further transmission follows, `err_count` holds `cfg_max_rep`, and `err_sticky` is set on the next cycle.
- R6: On a received character with correct parity, `rx_valid` pulses 12 ETUs after the start bit began and `rx_data` holds the byte. The line is not driven.
- R7: On a parity failure with the iteration count below `cfg_max_iter`, the engine pulls the line low from cycle `ETU_CLKS`/2 of the receive guard for `ETU_CLKS` cycles, emits no event, and waits for the repeat.
- R8: On a parity failure with the iteration count at `cfg_max_iter`, no error signal is driven. `rx_perr` pulses with `rx_data` holding the byte, and `err_sticky` is set on the next cycle. The count restarts at zero after any accepted character.
- R9: `tx_start` and `tx_data` have no effect while `busy` is high.
- R10: `err_clr` clears `err_sticky` on the next cycle unless a new failure event arrives in the same cycle.
- R11: A start bit that is high again at its mid-point aborts reception: `busy` drops on the following cycle and no event is produced.
- R12: `err_count` clears to zero when a new transmission is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_inverse | input | 1 | 1 selects the inverse data convention |
| cfg_max_rep | input | REP_W | Transmit repetition limit |
| cfg_max_iter | input | REP_W | Receive repeat-request limit |
| err_clr | input | 1 | Clears the sticky error flag |
| tx_start | input | 1 | Starts sending `tx_data` when idle |
| tx_data | input | 8 | Byte to send |
| busy | output | 1 | A character is in progress |
| tx_done | output | 1 | One-cycle pulse: character sent and not refused |
| tx_fail | output | 1 | One-cycle pulse: repetition limit exhausted |
| err_count | output | REP_W | Error signals seen for the current or last sent character |
| rx_valid | output | 1 | One-cycle pulse: byte received with good parity |
| rx_perr | output | 1 | One-cycle pulse: byte accepted with bad parity at the limit |
| rx_data | output | 8 | Last accepted received byte |
| err_sticky | output | 1 | Sticky flag for an exhausted limit |
| line_in | input | 1 | Synchronised level of the data line |
| line_drive_low | output | 1 | Pull-down enable for the data line |

## Verification
The bench's reference model predicts `line_drive_low`, `busy` and the four event pulses on every cycle. A bit-position or timer error therefore shows up at the ports within one ETU, as a wrong start, data or parity level, or as a late or early release of the line. A wrong convention mapping changes a data level in the first ETU that carries that bit. A repetition or iteration counter that is off by one shows up at the end of a guard period: it adds or removes a whole 12-ETU retransmission, or an error-signal pulse, and moves the `tx_fail` or `rx_perr` event accordingly. A wrong sticky flag appears one cycle after the event that should have set it.

// File: rtl/sc_link_pkg.sv
// Shared constants and the state type for the smart-card character link.
// Assumes a character of 8 data bits framed by one start and one parity bit.
package sc_link_pkg;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = DATA_W + 2;
    localparam int IDX_W   = $clog2(FRAME_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_BITS,
        ST_TX_GUARD,
        ST_RX_BITS,
        ST_RX_GUARD
    } link_state_e;
endpackage

// File: rtl/sc_frame_enc.sv
// Maps a byte to the line levels of one character frame (start, data, parity).
// Assumes even parity; the inverse convention complements levels and reverses order.
module sc_frame_enc
    import sc_link_pkg::*;
(
    input  logic [DATA_W-1:0]  data_i,
    input  logic               inverse_i,
    output logic [FRAME_W-1:0] frame_o
);
    logic par_logical;

    assign par_logical = ^data_i;
    assign frame_o[0]  = 1'b0;
    assign frame_o[FRAME_W-1] = inverse_i ? ~par_logical : par_logical;

    // One mapping per data slot; the convention picks order and polarity.
    for (genvar g = 0; g < DATA_W; g++) begin : g_slot
        assign frame_o[g+1] = inverse_i ? ~data_i[DATA_W-1-g] : data_i[g];
    end
endmodule

// File: rtl/sc_frame_dec.sv
// Recovers a byte and its parity status from captured line levels.
// Assumes the start bit has already been stripped by the caller.
module sc_frame_dec
    import sc_link_pkg::*;
(
    input  logic [FRAME_W-1:1] frame_i,
    input  logic               inverse_i,
    output logic [DATA_W-1:0]  data_o,
    output logic               par_ok_o
);
    logic par_logical;

    assign par_logical = inverse_i ? ~frame_i[FRAME_W-1] : frame_i[FRAME_W-1];
    assign par_ok_o    = ((^data_o) == par_logical);

    // Inverse of the encoder mapping, slot by slot.
    for (genvar g = 0; g < DATA_W; g++) begin : g_slot
        assign data_o[g] = inverse_i ? ~frame_i[DATA_W-g] : frame_i[g+1];
    end
endmodule

// File: rtl/sc_limit_counter.sv
// Small attempt counter with synchronous clear (priority) and increment.
// Assumes the caller stops incrementing at its limit.
module sc_limit_counter #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);
    // Count attempts; clear wins over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)     count_o <= '0;
        else if (clr_i) count_o <= '0;
        else if (inc_i) count_o <= count_o + 1'b1;
    end
endmodule

// File: rtl/sc_char_link.sv
// Half-duplex T=0 character engine on one open-drain line.
// Sends with error-signal detection and retransmission, receives with parity
// check and repeat requests. Assumes line_in is synchronised to clk and
// ETU_CLKS >= 4.
module sc_char_link
    import sc_link_pkg::*;
#(
    parameter int ETU_CLKS = 16,
    parameter int REP_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_inverse,
    input  logic [REP_W-1:0]  cfg_max_rep,
    input  logic [REP_W-1:0]  cfg_max_iter,
    input  logic              err_clr,
    input  logic              tx_start,
    input  logic [DATA_W-1:0] tx_data,
    output logic              busy,
    output logic              tx_done,
    output logic              tx_fail,
    output logic [REP_W-1:0]  err_count,
    output logic              rx_valid,
    output logic              rx_perr,
    output logic [DATA_W-1:0] rx_data,
    output logic              err_sticky,
    input  logic              line_in,
    output logic              line_drive_low
);
    localparam int TMR_W = $clog2(2 * ETU_CLKS);
    localparam logic [TMR_W-1:0] T_ETU_LAST   = TMR_W'(ETU_CLKS - 1);
    localparam logic [TMR_W-1:0] T_HALF       = TMR_W'(ETU_CLKS / 2);
    localparam logic [TMR_W-1:0] T_NACK_END   = TMR_W'(ETU_CLKS / 2 + ETU_CLKS);
    localparam logic [TMR_W-1:0] T_GUARD_LAST = TMR_W'(2 * ETU_CLKS - 1);
    localparam logic [IDX_W-1:0] IDX_LAST     = IDX_W'(FRAME_W - 1);

    link_state_e        state;
    logic [TMR_W-1:0]   tmr;
    logic [IDX_W-1:0]   bit_idx;
    logic [FRAME_W-1:0] tx_frame;
    logic [FRAME_W-1:0] enc_frame;
    logic [FRAME_W-1:1] rx_frame;
    logic [DATA_W-1:0]  dec_data;
    logic               dec_par_ok;
    logic               nack_seen;
    logic [REP_W-1:0]   iter_count;
    logic               rep_at_limit, iter_at_limit;
    logic               rep_clr, rep_inc, iter_clr, iter_inc;
    logic               etu_end, guard_end, rx_nack_req;

    sc_frame_enc u_enc (
        .data_i    (tx_data),
        .inverse_i (cfg_inverse),
        .frame_o   (enc_frame)
    );

    sc_frame_dec u_dec (
        .frame_i   (rx_frame),
        .inverse_i (cfg_inverse),
        .data_o    (dec_data),
        .par_ok_o  (dec_par_ok)
    );

    sc_limit_counter #(.W(REP_W)) u_rep_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (rep_clr),
        .inc_i   (rep_inc),
        .count_o (err_count)
    );

    sc_limit_counter #(.W(REP_W)) u_iter_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (iter_clr),
        .inc_i   (iter_inc),
        .count_o (iter_count)
    );

    // Timing points and counter controls derived from the current state.
    always_comb begin
        etu_end       = (tmr == T_ETU_LAST);
        guard_end     = (tmr == T_GUARD_LAST);
        rep_at_limit  = (err_count >= cfg_max_rep);
        iter_at_limit = (iter_count >= cfg_max_iter);
        rx_nack_req   = !dec_par_ok && !iter_at_limit;
        rep_clr  = (state == ST_IDLE) && tx_start;
        rep_inc  = (state == ST_TX_GUARD) && guard_end && nack_seen && !rep_at_limit;
        iter_clr = (state == ST_RX_GUARD) && guard_end && !rx_nack_req;
        iter_inc = (state == ST_RX_GUARD) && guard_end && rx_nack_req;
    end

    // Line pull-down: frame bits while sending, error signal while receiving.
    always_comb begin
        line_drive_low = 1'b0;
        if (state == ST_TX_BITS)
            line_drive_low = ~tx_frame[bit_idx];
        else if (state == ST_RX_GUARD && rx_nack_req && tmr >= T_HALF && tmr < T_NACK_END)
            line_drive_low = 1'b1;
    end

    assign busy = (state != ST_IDLE);

    // Character sequencer: bit timing, guard handling, retries and events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            tmr       <= '0;
            bit_idx   <= '0;
            tx_frame  <= '0;
            rx_frame  <= '0;
            nack_seen <= 1'b0;
            tx_done   <= 1'b0;
            tx_fail   <= 1'b0;
            rx_valid  <= 1'b0;
            rx_perr   <= 1'b0;
            rx_data   <= '0;
        end else begin
            tx_done  <= 1'b0;
            tx_fail  <= 1'b0;
            rx_valid <= 1'b0;
            rx_perr  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    bit_idx   <= '0;
                    nack_seen <= 1'b0;
                    if (tx_start) begin
                        tx_frame <= enc_frame;
                        tmr      <= '0;
                        state    <= ST_TX_BITS;
                    end else if (!line_in) begin
                        tmr   <= TMR_W'(1);
                        state <= ST_RX_BITS;
                    end else begin
                        tmr <= '0;
                    end
                end
                ST_TX_BITS: begin
                    if (etu_end) begin
                        tmr <= '0;
                        if (bit_idx == IDX_LAST) begin
                            bit_idx   <= '0;
                            nack_seen <= 1'b0;
                            state     <= ST_TX_GUARD;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_TX_GUARD: begin
                    tmr <= tmr + 1'b1;
                    if (tmr == T_ETU_LAST) nack_seen <= !line_in;
                    if (guard_end) begin
                        tmr <= '0;
                        if (!nack_seen) begin
                            tx_done <= 1'b1;
                            state   <= ST_IDLE;
                        end else if (rep_at_limit) begin
                            tx_fail <= 1'b1;
                            state   <= ST_IDLE;
                        end else begin
                            state <= ST_TX_BITS;
                        end
                    end
                end
                ST_RX_BITS: begin
                    if (tmr == T_HALF && bit_idx == '0 && line_in) begin
                        tmr   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        if (tmr == T_HALF && bit_idx != '0) rx_frame[bit_idx] <= line_in;
                        if (etu_end) begin
                            tmr <= '0;
                            if (bit_idx == IDX_LAST) begin
                                bit_idx <= '0;
                                state   <= ST_RX_GUARD;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end else begin
                            tmr <= tmr + 1'b1;
                        end
                    end
                end
                ST_RX_GUARD: begin
                    tmr <= tmr + 1'b1;
                    if (guard_end) begin
                        tmr   <= '0;
                        state <= ST_IDLE;
                        if (dec_par_ok) begin
                            rx_valid <= 1'b1;
                            rx_data  <= dec_data;
                        end else if (iter_at_limit) begin
                            rx_perr <= 1'b1;
                            rx_data <= dec_data;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Sticky error: set by an exhausted limit, cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n)                 err_sticky <= 1'b0;
        else if (tx_fail || rx_perr) err_sticky <= 1'b1;
        else if (err_clr)           err_sticky <= 1'b0;
    end
endmodule

// File: rtl/sc_char_link_chk.sv
// Port-level temporal checks for sc_char_link, attached with bind below.
module sc_char_link_chk #(
    parameter int REP_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_done,
    input logic             tx_fail,
    input logic             rx_valid,
    input logic             rx_perr,
    input logic             err_sticky,
    input logic             err_clr,
    input logic [REP_W-1:0] err_count,
    input logic [REP_W-1:0] cfg_max_rep
);
    // R5
    fail_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fail |-> (err_count == cfg_max_rep));

    // R2
    single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_done, tx_fail, rx_valid, rx_perr}));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count != $past(err_count)) |->
            ((err_count == $past(err_count) + 1'b1) || (err_count == '0)));

    // R8
    sticky_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_sticky) |-> $past(tx_fail || rx_perr));

    // R10
    sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !tx_fail && !rx_perr) |=> !err_sticky);
endmodule

bind sc_char_link sc_char_link_chk #(.REP_W(REP_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_done     (tx_done),
    .tx_fail     (tx_fail),
    .rx_valid    (rx_valid),
    .rx_perr     (rx_perr),
    .err_sticky  (err_sticky),
    .err_clr     (err_clr),
    .err_count   (err_count),
    .cfg_max_rep (cfg_max_rep)
);

// File: tb/sc_char_link_tb_top.sv
// Bench: behavioural card model plus a per-cycle expectation of the line,
// busy and event outputs, compared at every falling edge.
module sc_char_link_tb_top;
    localparam int E     = 16;
    localparam int HALF  = E / 2;
    localparam int REP_W = 3;

    logic clk = 1'b0;
    logic rst_n, cfg_inverse, err_clr, tx_start, card_low;
    logic [REP_W-1:0] cfg_max_rep, cfg_max_iter;
    logic [7:0] tx_data, rx_data;
    logic busy, tx_done, tx_fail, rx_valid, rx_perr, err_sticky, line_drive_low, line_in;
    logic [REP_W-1:0] err_count;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit exp_sticky = 1'b0;

    always #10 clk = ~clk;

    assign line_in = !(line_drive_low || card_low);

    sc_char_link #(.ETU_CLKS(E), .REP_W(REP_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_inverse(cfg_inverse),
        .cfg_max_rep(cfg_max_rep), .cfg_max_iter(cfg_max_iter), .err_clr(err_clr),
        .tx_start(tx_start), .tx_data(tx_data), .busy(busy), .tx_done(tx_done),
        .tx_fail(tx_fail), .err_count(err_count), .rx_valid(rx_valid),
        .rx_perr(rx_perr), .rx_data(rx_data), .err_sticky(err_sticky),
        .line_in(line_in), .line_drive_low(line_drive_low)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Line level of frame slot b for byte d, from the requirement text.
    function automatic logic lvl(input logic [7:0] d, input bit inv, input int b,
                                 input bit flip_par);
        logic p;
        if (b == 0) return 1'b0;
        if (b <= 8) return inv ? ~d[8-b] : d[b-1];
        p = ^d;
        if (flip_par) p = ~p;
        return inv ? ~p : p;
    endfunction

    // Compare the cycle's port picture {drive,busy,done,fail,rxv,perr}.
    task automatic step(input string req, input bit e_drv, input bit e_busy,
                        input bit e_done, input bit e_fail, input bit e_rxv,
                        input bit e_perr);
        logic [5:0] act, expv;
        @(negedge clk);
        act  = {line_drive_low, busy, tx_done, tx_fail, rx_valid, rx_perr};
        expv = {e_drv, e_busy, e_done, e_fail, e_rxv, e_perr};
        chk(act == expv, req, "drv/busy/done/fail/rxv/perr", int'(act), int'(expv));
    endtask

    task automatic idle_and_sticky(input string req);
        step(req, 0, 0, 0, 0, 0, 0);
        chk(err_sticky == exp_sticky, req, "err_sticky", int'(err_sticky), int'(exp_sticky));
    endtask

    // Send byte d; the card refuses the first `nacks` attempts.
    task automatic run_tx(input logic [7:0] d, input bit inv, input int nacks,
                          input bit poke, input string req);
        int attempts;
        bit fail;
        int max_rep;
        max_rep  = int'(cfg_max_rep);
        fail     = (nacks > max_rep);
        attempts = fail ? max_rep + 1 : nacks + 1;
        cfg_inverse = inv;
        tx_data  = d;
        tx_start = 1'b1;
        for (int a = 0; a < attempts; a++) begin
            for (int k = 0; k < 12 * E; k++) begin
                step(req, (k < 10 * E) ? !lvl(d, inv, k / E, 1'b0) : 1'b0, 1, 0, 0, 0, 0);
                tx_start = 1'b0;
                if (poke && a == 0 && k == 20) begin  // R9: start while busy
                    tx_start = 1'b1;
                    tx_data  = ~d;
                end
                card_low = (a < nacks) && (k >= 10 * E + HALF) && (k < 11 * E + HALF);
            end
        end
        step(req, 0, 0, !fail, fail, 0, 0);
        chk(int'(err_count) == (fail ? max_rep : nacks), req, "err_count",
            int'(err_count), fail ? max_rep : nacks);
        if (fail) exp_sticky = 1'b1;
        idle_and_sticky(req);
    endtask

    // Card sends byte d; the first `bad_n` copies carry a wrong parity bit.
    task automatic run_rx(input logic [7:0] d, input bit inv, input int bad_n,
                          input string req);
        int iter;
        bit done, bad, nack, acc_bad;
        iter = 0;
        done = 0;
        acc_bad = 0;
        cfg_inverse = inv;
        while (!done) begin
            bad  = (iter < bad_n);
            nack = bad && (iter < int'(cfg_max_iter));
            for (int j = 0; j < 12 * E; j++) begin
                step(req, nack && (j >= 10 * E + HALF) && (j < 11 * E + HALF),
                     j >= 1, 0, 0, 0, 0);
                card_low = (j < 10 * E) ? !lvl(d, inv, j / E, bad) : 1'b0;
            end
            if (nack) iter++;
            else begin
                done = 1;
                acc_bad = bad;
            end
        end
        step(req, 0, 0, 0, 0, !acc_bad, acc_bad);
        chk(rx_data == d, req, "rx_data", int'(rx_data), int'(d));
        if (acc_bad) exp_sticky = 1'b1;
        idle_and_sticky(req);
    endtask

    initial begin
        rst_n = 1'b0; card_low = 1'b0; tx_start = 1'b0; tx_data = '0; err_clr = 1'b0;
        cfg_inverse = 1'b0; cfg_max_rep = 3'd2; cfg_max_iter = 3'd3;
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk({line_drive_low, busy, tx_done, tx_fail, rx_valid, rx_perr} == '0, "R1",
            "outputs in reset", int'(busy), 0);
        rst_n = 1'b1;
        step("R1", 0, 0, 0, 0, 0, 0);
        chk(err_count == '0 && err_sticky == 1'b0 && rx_data == '0, "R1",
            "count/sticky/data", int'(err_count), 0);

        run_tx(8'hA5, 0, 0, 0, "R2");
        run_tx(8'h3B, 1, 0, 0, "R3");
        run_tx(8'h96, 0, 0, 1, "R9");
        run_tx(8'hC3, 0, 2, 0, "R4");
        run_tx(8'h5A, 0, 3, 0, "R5");

        // R10: clear the sticky flag
        err_clr = 1'b1;
        step("R10", 0, 0, 0, 0, 0, 0);
        err_clr = 1'b0;
        exp_sticky = 1'b0;
        chk(err_sticky == 1'b0, "R10", "err_sticky", int'(err_sticky), 0);

        run_tx(8'h0F, 0, 0, 0, "R12");
        cfg_max_rep = 3'd0;
        run_tx(8'h11, 0, 1, 0, "R5");
        err_clr = 1'b1;
        step("R10", 0, 0, 0, 0, 0, 0);
        err_clr = 1'b0;
        exp_sticky = 1'b0;

        run_rx(8'h5C, 0, 0, "R6");
        run_rx(8'hC1, 1, 0, "R3");
        run_rx(8'hE7, 0, 1, "R7");
        cfg_max_iter = 3'd1;
        run_rx(8'h29, 0, 5, "R8");

        // R11: glitch shorter than half a bit
        for (int j = 0; j < HALF + 5; j++) begin
            step("R11", 0, (j >= 1) && (j <= HALF), 0, 0, 0, 0);
            card_low = (j < 2);
        end
        chk(rx_data == 8'h29, "R11", "rx_data unchanged", int'(rx_data), 8'h29);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule